// File: doc/BRIEF.md
# Multiplexed parallel I/O port

This block is a sixteen-pin parallel port in which every pin either works as a general-purpose input/output or is handed to an on-chip peripheral. Four registers control it, reached over a simple valid/write bus. They are an output latch, a direction word, a function-select word and an open-drain word. For a pin handed to a peripheral, the direction bit chooses between two roles. In the output role the peripheral drives the pin. In the input role the pin's synchronized level feeds the peripheral input vectors.

The block also routes pin levels to the peripheral inputs. When a peripheral input is not taken from its own pin, it receives a fixed fallback: ground, one of the internal source signals, or the level on another pin. A read of the latch offset always returns the synchronized pin levels, never the latch contents. Open-drain control exists only on a fixed subset of bit positions. Every pin input passes through a two-flop synchronizer before any use.

The bus interface is a two-state machine. `BUS_IDLE` moves to `BUS_RESP` on a read request. `BUS_RESP` stays in `BUS_RESP` when another read is requested and returns to `BUS_IDLE` otherwise. The response valid signal is high exactly while the machine is in `BUS_RESP`.

Top module: `pio_port`

## Requirements
- R1: After reset all four registers are zero: every pin is a general-purpose input with push-pull drive, `pin_oe` is all zero, and reads of offsets 1, 2 and 3 return 0.
- R2: Word offsets are fixed: 0 selects the latch/data register, 1 direction, 2 function select, 3 open-drain. Register bit k is the most significant bit when k = 0, so register bit k sits in word bit 15-k and controls pin k (`pin_*[k]`, `per_*[k]`).
- R3: Every write to offset 0 is stored in the latch whatever the pin's direction or function. A value written while a pin is an input appears on `pin_o` once the pin is later made a general-purpose output.
- R4: A pin whose direction bit is 0 is never driven (`pin_oe[k]` = 0), in either function.
- R5: A read of offset 0 returns the pin levels in word bit 15-k, not the latch. A pin change is visible to a read issued two clock edges after the change, and not to a read issued at the first edge.
- R6: With function select 1 and direction 1, pin k drives `per_out[k]` with `pin_oe[k]` = 1. With function select 0 and direction 1, pin k drives its latch bit.
- R7: With function select 1 and direction 0, both `per_in[k]` and `per_in_alt[k]` carry the synchronized level of pin k, so one pin feeds two peripheral inputs at once.
- R8: When pin k is not a peripheral input, `per_in_alt[k]` = 0. `per_in[k]` takes a fallback chosen by k mod 4: 0 or 2 gives 0, 1 gives `src_in[(k/4) mod 4]`, and 3 gives the synchronized level of pin k-3.
- R9: Open-drain bits exist only at register bits 8 to 12 and 14 (word mask 0x00FA). Writes to other bits are ignored and those bits read 0. On an open-drain pin that is driving, `pin_oe` is 1 only when the drive value is 0, and `pin_o` is then 0.
- R10: A read request produces `bus_rvalid` = 1 with its data on the cycle after the request. A write never produces `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word offset |
| bus_wdata | input | 16 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 16 | Read data |
| pin_i | input | 16 | Pin levels from the pads |
| pin_o | output | 16 | Pin drive values |
| pin_oe | output | 16 | Pin output enables |
| per_out | input | 16 | Peripheral output functions, one per pin |
| src_in | input | 4 | Internal fallback sources for peripheral inputs |
| per_in | output | 16 | Primary peripheral inputs, one per pin |
| per_in_alt | output | 16 | Secondary peripheral inputs sharing the same pins |

## Verification
The hardest situation to reach from the ports is a fallback that uses another pin (k mod 4 = 3), checked while that other pin is itself configured in an unrelated way. The same care applies to a latch value written while a pin is an input and only revealed later. The bench reaches both by sweeping many derived patterns of function, direction, open-drain, latch, pin level and peripheral drive. It waits for the synchronizer to settle and compares every pin against values computed per bit. A dedicated sequence writes the latch under an input direction, reads the pins back, and then flips the direction to expose the held value.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int PIO_W    = 16;
    localparam int PIO_NSRC = 4;
    localparam logic [PIO_W-1:0] PIO_OD_MASK = 16'h00FA;

    typedef enum logic [1:0] {
        OFF_LATCH = 2'd0,
        OFF_DIR   = 2'd1,
        OFF_FSEL  = 2'd2,
        OFF_ODRN  = 2'd3
    } pio_off_e;

    typedef enum logic [1:0] {
        DEF_GND = 2'd0,
        DEF_SRC = 2'd1,
        DEF_PIN = 2'd2
    } pio_def_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } pio_bus_e;

    // Fallback kind for the primary peripheral input of pin k
    function automatic pio_def_e def_kind(input int k);
        case (k % 4)
            1:       return DEF_SRC;
            3:       return DEF_PIN;
            default: return DEF_GND;
        endcase
    endfunction
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            q       <= '0;
        end else begin
            stage_q <= d;
            q       <= stage_q;
        end
    end
endmodule

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
#(
    parameter int           W       = PIO_W,
    parameter logic [W-1:0] OD_MASK = PIO_OD_MASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_valid,
    input  logic         bus_write,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic         bus_rvalid,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pin_s,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] fsel_q,
    output logic [W-1:0] odrn_q
);
    pio_bus_e     state_q, state_d;
    logic [W-1:0] rdata_q;
    logic [W-1:0] pin_word;
    logic [W-1:0] rd_mux;
    logic         rd_req, wr_req;

    assign rd_req = bus_valid && !bus_write;
    assign wr_req = bus_valid && bus_write;

    // pin k lands in word bit W-1-k
    for (genvar k = 0; k < W; k++) begin : g_word
        assign pin_word[W-1-k] = pin_s[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            BUS_IDLE: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd_req ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        bus_rvalid = (state_q == BUS_RESP);
        bus_rdata  = rdata_q;
    end

    always_comb begin
        unique case (pio_off_e'(bus_addr))
            OFF_LATCH: rd_mux = pin_word;
            OFF_DIR:   rd_mux = dir_q;
            OFF_FSEL:  rd_mux = fsel_q;
            OFF_ODRN:  rd_mux = odrn_q;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
            fsel_q  <= '0;
            odrn_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (wr_req) begin
                unique case (pio_off_e'(bus_addr))
                    OFF_LATCH: latch_q <= bus_wdata;
                    OFF_DIR:   dir_q   <= bus_wdata;
                    OFF_FSEL:  fsel_q  <= bus_wdata;
                    OFF_ODRN:  odrn_q  <= bus_wdata & OD_MASK;
                    default:   ;
                endcase
            end
            if (rd_req) rdata_q <= rd_mux;
        end
    end

    // R3: a latch write is kept regardless of direction or function
    a_r3_latch_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && bus_addr == 2'd0) |=> (latch_q == $past(bus_wdata)));
    // R9: open-drain bits outside the mask stay clear
    a_r9_od_mask: assert property (@(posedge clk) disable iff (!rst_n)
        ((odrn_q & ~OD_MASK) == '0));
    // R10: read answered on the next cycle
    a_r10_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);
    // R10: no response without a read request
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(rd_req));
endmodule

// File: rtl/pio_pad.sv
module pio_pad #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] fsel_q,
    input  logic [W-1:0] odrn_q,
    input  logic [W-1:0] per_out,
    output logic [W-1:0] pin_o,
    output logic [W-1:0] pin_oe
);
    for (genvar k = 0; k < W; k++) begin : g_pin
        localparam int B = W - 1 - k;
        logic drv;
        assign drv       = fsel_q[B] ? per_out[k] : latch_q[B];
        assign pin_o[k]  = odrn_q[B] ? 1'b0 : drv;
        assign pin_oe[k] = dir_q[B] & ~(odrn_q[B] & drv);

        // R9: an open-drain pin never drives high
        a_r9_od_low_only: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_oe[k] && odrn_q[B]) |-> !pin_o[k]);
        // R4: an input-direction pin is released
        a_r4_input_released: assert property (@(posedge clk) disable iff (!rst_n)
            !dir_q[B] |-> !pin_oe[k]);
    end
endmodule

// File: rtl/pio_route.sv
module pio_route
    import pio_pkg::*;
#(
    parameter int W    = PIO_W,
    parameter int NSRC = PIO_NSRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    pin_s,
    input  logic [W-1:0]    dir_q,
    input  logic [W-1:0]    fsel_q,
    input  logic [NSRC-1:0] src_in,
    output logic [W-1:0]    per_in,
    output logic [W-1:0]    per_in_alt
);
    for (genvar k = 0; k < W; k++) begin : g_rt
        localparam int       B    = W - 1 - k;
        localparam pio_def_e KIND = def_kind(k);
        logic take, fallback;
        assign take = fsel_q[B] & ~dir_q[B];

        if (KIND == DEF_SRC) begin : g_src
            assign fallback = src_in[(k / 4) % NSRC];
        end else if (KIND == DEF_PIN) begin : g_pin
            assign fallback = pin_s[k - 3];
        end else begin : g_gnd
            assign fallback = 1'b0;
        end

        assign per_in[k]     = take ? pin_s[k] : fallback;
        assign per_in_alt[k] = take & pin_s[k];

        // R7: a pin used as a peripheral input feeds both inputs alike
        a_r7_shared_feed: assert property (@(posedge clk) disable iff (!rst_n)
            take |-> (per_in[k] == per_in_alt[k]));
        // R8: the secondary input is quiet when not pin-sourced
        a_r8_alt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !take |-> !per_in_alt[k]);
    end
endmodule

// File: rtl/pio_port.sv
module pio_port
    import pio_pkg::*;
#(
    parameter int           W       = PIO_W,
    parameter int           NSRC    = PIO_NSRC,
    parameter logic [W-1:0] OD_MASK = PIO_OD_MASK
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_valid,
    input  logic            bus_write,
    input  logic [1:0]      bus_addr,
    input  logic [W-1:0]    bus_wdata,
    output logic            bus_rvalid,
    output logic [W-1:0]    bus_rdata,
    input  logic [W-1:0]    pin_i,
    output logic [W-1:0]    pin_o,
    output logic [W-1:0]    pin_oe,
    input  logic [W-1:0]    per_out,
    input  logic [NSRC-1:0] src_in,
    output logic [W-1:0]    per_in,
    output logic [W-1:0]    per_in_alt
);
    logic [W-1:0] pin_s, latch_q, dir_q, fsel_q, odrn_q;

    pio_sync #(.W(W)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_i), .q(pin_s)
    );

    pio_regs #(.W(W), .OD_MASK(OD_MASK)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .pin_s(pin_s), .latch_q(latch_q), .dir_q(dir_q),
        .fsel_q(fsel_q), .odrn_q(odrn_q)
    );

    pio_pad #(.W(W)) u_pad (
        .clk(clk), .rst_n(rst_n),
        .latch_q(latch_q), .dir_q(dir_q), .fsel_q(fsel_q), .odrn_q(odrn_q),
        .per_out(per_out), .pin_o(pin_o), .pin_oe(pin_oe)
    );

    pio_route #(.W(W), .NSRC(NSRC)) u_route (
        .clk(clk), .rst_n(rst_n),
        .pin_s(pin_s), .dir_q(dir_q), .fsel_q(fsel_q), .src_in(src_in),
        .per_in(per_in), .per_in_alt(per_in_alt)
    );
endmodule

// File: tb/pio_port_tb.sv
module pio_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] ODM = 16'h00FA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [15:0] bus_rdata;
    logic [15:0] pin_i = '0, pin_o, pin_oe, per_out = '0, per_in, per_in_alt;
    logic [3:0]  src_in = '0;

    int n_chk = 0, n_bad = 0;

    pio_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe),
        .per_out(per_out), .src_in(src_in), .per_in(per_in), .per_in_alt(per_in_alt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        chk("R10 write gives no rvalid", {15'd0, bus_rvalid}, 16'd0);
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0;
        chk("R10 read rvalid next cycle", {15'd0, bus_rvalid}, 16'd1);
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [15:0] rev16(input logic [15:0] v);
        logic [15:0] r;
        for (int k = 0; k < 16; k++) r[k] = v[15-k];
        return r;
    endfunction

    // Check the pads and the peripheral inputs for one configuration (word order regs)
    task automatic check_all(input logic [15:0] sel, dir, od, lat, input string tag);
        logic [15:0] eo, eoe, epi, ealt;
        for (int k = 0; k < 16; k++) begin
            int b = 15 - k;
            logic v, take;
            v = sel[b] ? per_out[k] : lat[b];
            if (od[b] && ODM[b]) begin
                eoe[k] = dir[b] & ~v; eo[k] = 1'b0;
            end else begin
                eoe[k] = dir[b]; eo[k] = v;
            end
            take = sel[b] & ~dir[b];
            case (k % 4)
                1:       epi[k] = src_in[(k/4) % 4];
                3:       epi[k] = pin_i[k-3];
                default: epi[k] = 1'b0;
            endcase
            if (take) epi[k] = pin_i[k];
            ealt[k] = take & pin_i[k];
        end
        chk({"R4 R6 R9 pin_oe ", tag}, pin_oe, eoe);
        chk({"R3 R6 R9 pin_o ", tag}, pin_o & eoe, eo & eoe);
        chk({"R7 R8 per_in ", tag}, per_in, epi);
        chk({"R7 R8 per_in_alt ", tag}, per_in_alt, ealt);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1 reset state
        chk("R1 pin_oe after reset", pin_oe, 16'h0000);
        rd(2'd1, d); chk("R1 dir reset", d, 16'h0000);
        rd(2'd2, d); chk("R1 fsel reset", d, 16'h0000);
        rd(2'd3, d); chk("R1 odrn reset", d, 16'h0000);
        check_all('0, '0, '0, '0, "R1 reset");

        // R9 mask: only 0x00FA is kept
        wr(2'd3, 16'hFFFF); rd(2'd3, d); chk("R9 od readback", d, ODM);
        wr(2'd3, 16'h0000);

        // R3 latch held under input, R5 read returns pins not latch
        pin_i = 16'h0000;
        wr(2'd0, 16'hFFFF);
        wait_cyc(3);
        chk("R3 R4 latch hidden on input", pin_oe, 16'h0000);
        rd(2'd0, d); chk("R5 read returns pins not latch", d, 16'h0000);
        wr(2'd1, 16'hFFFF);
        chk("R3 latch revealed on output oe", pin_oe, 16'hFFFF);
        chk("R3 latch revealed on output", pin_o, 16'hFFFF);

        // R5 synchronizer timing and bit order (R2)
        pin_i = 16'h0001;
        rd(2'd0, d); chk("R5 first-edge read still old", d, 16'h0000);
        pin_i = 16'h0003;
        wait_cyc(2);
        rd(2'd0, d); chk("R5 R2 pin0 in word msb", d, 16'hC000);
        wr(2'd1, 16'h0000);

        // R2 bit order on direction: register bit 0 (word msb) -> pin 0
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h8000);
        chk("R2 dir msb drives pin0", pin_oe, 16'h0001);
        wr(2'd1, 16'h0000);

        // Sweep of derived configurations
        for (int c = 0; c < 48; c++) begin
            logic [15:0] sel, dir, od, lat;
            sel     = 16'(c * 32'h1357) ^ 16'hC6A5;
            dir     = 16'(c * 32'h2A6B) ^ 16'h0F0F;
            od      = 16'(c * 32'h4C1D) ^ 16'h3C96;
            lat     = 16'(c * 32'h7E35) ^ 16'h5A5A;
            per_out = 16'(c * 32'h3939) ^ 16'h9C63;
            src_in  = 4'(c * 7 + 3);
            pin_i   = 16'(c * 32'h5A17) ^ 16'hA1B2;
            wr(2'd2, sel); wr(2'd1, dir); wr(2'd3, od); wr(2'd0, lat);
            wait_cyc(3);
            check_all(sel, dir, od, lat, "sweep");
            rd(2'd0, d); chk("R5 sweep pin read", d, rev16(pin_i));
            rd(2'd3, d); chk("R9 sweep od read", d, od & ODM);
            rd(2'd2, d); chk("R2 sweep fsel read", d, sel);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule